// File: doc/BRIEF.md
# Serial Trim-Capacitor Configuration Register

This block programs the switch enables of the trim-capacitor banks on a four-capacitor continuous-time filter. A configuration word arrives one bit per clock on a serial data input and moves through a shift chain. Each bit position in the chain is a pair of flip-flops: a rising-edge stage followed by a falling-edge stage. Because every stage samples a neighbour that changes on the opposite edge, each stage has half a clock period of setup and half a clock period of hold. Both margins therefore depend only on the clock period, and no clock-tree skew balancing is needed.

The chain shifts on every clock cycle. When the synchronous load enable is high at a rising edge, a holding register captures the whole chain as it stood before that edge's shift, and the trim-bank enables change only then. The holding register is split into two 12-enable banks for the smaller capacitors and two 15-enable banks for the larger capacitors. The last chain stage drives a serial output, so a shifted pattern can be read back.

Top module: `trim_cfg_shift`

## Requirements
- R1: An active-low asynchronous reset clears every chain stage and the holding register, so all trim enables read 0 and ser_out reads 0.
- R2: At each rising edge, rising stage k (k from 1 to 53) takes the value that falling stage k-1 held just before that edge.
- R3: At each falling edge, falling stage k takes the value of rising stage k.
- R4: At every rising edge, rising stage 0 samples ser_in. The chain shifts on every cycle and has no shift enable.
- R5: When load_en is high at a rising edge, the holding register captures the 54 falling-stage values from before that edge. This is also true when a new bit shifts in on the same edge.
- R6: When load_en is low at a rising edge, every trim enable keeps its value.
- R7: Chain position 0 is the one nearest ser_in. Small bank i (i = 0 or 1) drives chain bits [12i+11:12i]. Large bank j (j = 0 or 1) drives chain bits [24+15j+14:24+15j]. A 54-bit word shifted most-significant bit first therefore lands as {large bank 1, large bank 0, small bank 1, small bank 0}, and the first bit shifted in ends up in large bank 1 bit 14.
- R8: ser_out is falling stage 53. A bit sampled from ser_in at rising edge N appears on ser_out after falling edge N+53.
- R9: ser_out changes only at falling edges, half a period after the rising edge that shifts the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock. Rising and falling stages use opposite edges. |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_in | input | 1 | Serial configuration data, sampled at the rising edge |
| load_en | input | 1 | Synchronous load of the holding register |
| ser_out | output | 1 | Last chain stage, used for readback |
| small_trim_en | output | 2x12 | Enables for the two smaller-capacitor trim banks |
| large_trim_en | output | 2x15 | Enables for the two larger-capacitor trim banks |

## Verification
A stage that skips, duplicates or drops a bit shows up on ser_out within 54 cycles, as a readback stream that differs from the one shifted in. It also shows up after the next load as wrong enables in the bank that holds that position. A wrong bank mapping or ordering shows at the ports right after the first load of an asymmetric pattern. A falling stage clocked on the wrong edge moves ser_out half a cycle early, and sampling ser_out after both edges catches this. A holding register that leaks chain values without a load shows as enables changing in the middle of a shift.

// File: rtl/trim_cfg_pkg.sv
package trim_cfg_pkg;
    localparam int SMALL_BITS  = 12;
    localparam int LARGE_BITS  = 15;
    localparam int SMALL_BANKS = 2;
    localparam int LARGE_BANKS = 2;
    localparam int CHAIN_BITS  = SMALL_BANKS * SMALL_BITS + LARGE_BANKS * LARGE_BITS;
endpackage

// File: rtl/trim_shift_chain.sv
module trim_shift_chain #(
    parameter int N = 54
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    output logic [N-1:0] chain_o,
    output logic         ser_out
);
    typedef struct packed {
        logic [N-1:0] stage;
    } rise_t;

    typedef struct packed {
        logic [N-1:0] stage;
    } fall_t;

    rise_t rise_d, rise_q;
    fall_t fall_d, fall_q;

    // next-state: rising stages take the preceding falling stage
    always_comb begin
        rise_d       = rise_q;
        rise_d.stage = {fall_q.stage[N-2:0], ser_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    // next-state: falling stages take the rising stage of the same index
    always_comb begin
        fall_d       = fall_q;
        fall_d.stage = rise_q.stage;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= fall_d;
    end

    assign chain_o = fall_q.stage;
    assign ser_out = fall_q.stage[N-1];

    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (rise_q == '0 && fall_q == '0));

    p_head_samples_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> rise_q.stage[0] == $past(ser_in));

    for (genvar k = 1; k < N; k++) begin : g_rise_chk
        p_rise_follows_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> rise_q.stage[k] == $past(fall_q.stage[k-1]));
    end

    for (genvar k = 0; k < N; k++) begin : g_fall_chk
        p_fall_follows_rise_r3: assert property (@(negedge clk) disable iff (!rst_n)
            1'b1 |=> fall_q.stage[k] == $past(rise_q.stage[k]));
    end
endmodule

// File: rtl/trim_hold_reg.sv
module trim_hold_reg #(
    parameter int N = 54
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_en,
    input  logic [N-1:0] chain_i,
    output logic [N-1:0] hold_o
);
    typedef struct packed {
        logic [N-1:0] bits;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load_en) hold_d.bits = chain_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold_o = hold_q.bits;

    p_hold_reset_r1: assert property (@(posedge clk)
        !rst_n |=> hold_q == '0);

    p_load_captures_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> hold_q.bits == $past(chain_i));

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> $stable(hold_q));
endmodule

// File: rtl/trim_cfg_shift.sv
module trim_cfg_shift
    import trim_cfg_pkg::*;
#(
    parameter int SB = SMALL_BITS,
    parameter int LB = LARGE_BITS,
    parameter int NS = SMALL_BANKS,
    parameter int NL = LARGE_BANKS
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ser_in,
    input  logic                  load_en,
    output logic                  ser_out,
    output logic [NS-1:0][SB-1:0] small_trim_en,
    output logic [NL-1:0][LB-1:0] large_trim_en
);
    localparam int SMALL_TOTAL = NS * SB;
    localparam int TOTAL       = SMALL_TOTAL + NL * LB;

    logic [TOTAL-1:0] chain_w;
    logic [TOTAL-1:0] hold_w;

    trim_shift_chain #(.N(TOTAL)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .chain_o (chain_w),
        .ser_out (ser_out)
    );

    trim_hold_reg #(.N(TOTAL)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_en (load_en),
        .chain_i (chain_w),
        .hold_o  (hold_w)
    );

    // bank map (R7): small banks nearest the input, large banks at the far end
    for (genvar i = 0; i < NS; i++) begin : g_small
        assign small_trim_en[i] = hold_w[i*SB +: SB];
    end

    for (genvar j = 0; j < NL; j++) begin : g_large
        assign large_trim_en[j] = hold_w[SMALL_TOTAL + j*LB +: LB];
    end

    p_out_zero_in_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (ser_out == 1'b0 && small_trim_en == '0 && large_trim_en == '0));
endmodule

// File: tb/tb_trim_cfg_shift.sv
module tb_trim_cfg_shift;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic load_en = 1'b0;
    logic ser_out;
    logic [1:0][11:0] small_trim_en;
    logic [1:0][14:0] large_trim_en;

    trim_cfg_shift dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ser_in        (ser_in),
        .load_en       (load_en),
        .ser_out       (ser_out),
        .small_trim_en (small_trim_en),
        .large_trim_en (large_trim_en)
    );

    always #5 clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [53:0] exp_chain = '0;
    logic [53:0] exp_hold  = '0;
    logic        sdo_after_rise;

    localparam logic [53:0] PATS [4] = '{
        54'h3FFFFFFFFFFFFF,
        54'h2AAAAAAAAAAAAA,
        54'h20000000000001,
        54'h0F0F0F3C3C3C5A
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [53:0] banks_now();
        return {large_trim_en[1], large_trim_en[0], small_trim_en[1], small_trim_en[0]};
    endfunction

    // one clock: inputs held across the rising edge; returns at falling edge + 1
    task automatic cycle(input logic b, input logic ld);
        ser_in  = b;
        load_en = ld;
        @(posedge clk);
        if (ld) exp_hold = exp_chain;
        exp_chain = {exp_chain[52:0], b};
        #1;
        sdo_after_rise = ser_out;
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1: reset state
        chk(banks_now() == '0, "R1 enables after reset", 64'(banks_now()), 0);
        chk(ser_out == 1'b0, "R1 ser_out after reset", 64'(ser_out), 0);
        rst_n = 1'b1;

        foreach (PATS[p]) begin
            for (int i = 53; i >= 0; i--) begin
                logic [53:0] prev;
                prev = exp_chain;
                cycle(PATS[p][i], 1'b0);
                // R8: readback stream is the last stage of the chain
                chk(ser_out == exp_chain[53], "R8 ser_out readback", 64'(ser_out), 64'(exp_chain[53]));
                if (i == 20) begin
                    // R9: after the rising edge ser_out still shows the old last stage
                    chk(sdo_after_rise == prev[53], "R9 ser_out moves on falling edge",
                        64'(sdo_after_rise), 64'(prev[53]));
                    // R6: enables unchanged while shifting without load
                    chk(banks_now() == exp_hold, "R6 enables hold without load",
                        64'(banks_now()), 64'(exp_hold));
                end
            end
            cycle(1'b0, 1'b1);
            // R5 and R7: loaded word lands in the banks in the stated order
            chk(banks_now() == PATS[p], "R5 load captures pattern", 64'(banks_now()), 64'(PATS[p]));
            chk(large_trim_en[1] == PATS[p][53:39], "R7 large bank 1", 64'(large_trim_en[1]), 64'(PATS[p][53:39]));
            chk(large_trim_en[0] == PATS[p][38:24], "R7 large bank 0", 64'(large_trim_en[0]), 64'(PATS[p][38:24]));
            chk(small_trim_en[1] == PATS[p][23:12], "R7 small bank 1", 64'(small_trim_en[1]), 64'(PATS[p][23:12]));
            chk(small_trim_en[0] == PATS[p][11:0], "R7 small bank 0", 64'(small_trim_en[0]), 64'(PATS[p][11:0]));
        end

        // R7: first bit shifted in reaches large bank 1 bit 14
        chk(large_trim_en[1][14] == 1'b0 && PATS[3][53] == 1'b0, "R7 first bit to MSB",
            64'(large_trim_en[1][14]), 0);

        // R4 and R8: a single one travels 54 positions to ser_out
        cycle(1'b1, 1'b0);
        for (int n = 0; n < 52; n++) cycle(1'b0, 1'b0);
        chk(ser_out == 1'b0, "R8 bit not early", 64'(ser_out), 0);
        cycle(1'b0, 1'b0);
        chk(ser_out == 1'b1, "R4 bit reaches ser_out after 54 shifts", 64'(ser_out), 1);

        // R5: load on the same edge as a shift takes the pre-shift chain
        for (int i = 53; i >= 1; i--) cycle(PATS[2][i], 1'b0);
        cycle(PATS[2][0], 1'b1);
        chk(banks_now() == {1'b0, PATS[2][53:1]}, "R5 load with shift uses old chain",
            64'(banks_now()), 64'({1'b0, PATS[2][53:1]}));
        chk(banks_now() == exp_hold, "R5 load with shift model", 64'(banks_now()), 64'(exp_hold));

        // R1: asynchronous reset mid-run
        cycle(1'b1, 1'b1);
        #2;
        rst_n = 1'b0;
        #1;
        chk(banks_now() == '0, "R1 async reset clears enables", 64'(banks_now()), 0);
        chk(ser_out == 1'b0, "R1 async reset clears ser_out", 64'(ser_out), 0);
        exp_chain = '0;
        exp_hold  = '0;
        @(negedge clk);
        #1;
        rst_n = 1'b1;
        cycle(1'b0, 1'b1);
        chk(banks_now() == '0, "R1 chain cleared by reset", 64'(banks_now()), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule